// File: doc/BRIEF.md
# Dual-Channel DMA Enable and Soft-Reset Controller

This block is the control front end of a two-channel DMA engine that sits next to a USB device controller. It holds one global enable bit and accepts per-channel soft-reset commands through a small 32-bit, word-aligned register port. Each channel's transfer request is passed on only while the engine is enabled and the channel has no reset in flight. Dropping the enable freezes the channels where they are, and raising it lets them continue.

A soft reset does not cut a channel off in the middle of a transfer. The command is held as pending until the channel reports that it is not busy. The block then issues a single-cycle clear pulse, which empties the channel's FIFO and returns its registers to their reset values, and the channel becomes free again. A USB bus reset is brought in as an input but changes nothing here. Only the system reset and the soft-reset command clear state.

Top module: `dmac_top`

## Requirements
- R1: After system reset `rst` (synchronous, active high), the enable is 0, every `ch_rst_pend`, `ch_flush`, `ch_go` and `ch_xfer_req` is 0, and a read of offset 0x000 returns 0.
- R2: A write (`reg_sel`=1, `reg_we`=1) to offset 0x000 loads the enable from `reg_wdata[0]` at that clock edge. Bits 31:1 of the written word are ignored, and a read of offset 0x000 returns the enable in bit 0 with zeros in bits 31:1.
- R3: `ch_go[i]` equals enable AND NOT `ch_rst_pend[i]`, and `ch_xfer_req[i]` equals `ch_req[i]` AND `ch_go[i]`. Clearing the enable withholds the requests, and setting it again passes them on.
- R4: A write to offset 0x004 with bit i set (bit 0 for channel 0, bit 1 for channel 1, both bits for both channels) raises `ch_rst_pend[i]` from the next cycle. A 0 in a bit leaves that channel alone, and reads of offset 0x004 return 0.
- R5: If `ch_busy[i]` is 0 at the first edge after the write edge, `ch_flush[i]` is 1 for exactly one cycle starting at that edge, and `ch_rst_pend[i]` falls at the edge after that.
- R6: While `ch_busy[i]` is 1, a pending reset stays pending with no flush. The flush starts at the first edge at which `ch_busy[i]` is seen as 0.
- R7: A soft reset written while the enable is 0 follows the R5 timing when the channel is not busy. `ch_go` stays 0 throughout.
- R8: `usb_bus_rst` has no effect on the enable, on pending resets or on any output.
- R9: `reg_rdata` is combinational from the current address. Accesses are decoded only at offsets 0x000 and 0x004 with `reg_addr[1:0]`=0. Writes to any other address are ignored, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high |
| usb_bus_rst | input | 1 | USB bus reset indication, no effect on state |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset within the block |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| ch_req | input | 2 | Per-channel transfer request from the channel |
| ch_busy | input | 2 | Per-channel transfer-in-progress flag |
| ch_go | output | 2 | Per-channel permission to run |
| ch_xfer_req | output | 2 | Gated transfer request |
| ch_flush | output | 2 | One-cycle FIFO flush and channel register clear |
| ch_rst_pend | output | 2 | Soft reset pending or being applied |

## Verification
Register writes take effect at the edge that samples them. The enable and `ch_rst_pend` therefore change one cycle after the write. `ch_flush` rises at the following edge at the earliest, and the pending flag falls one edge after the flush. `ch_go`, `ch_xfer_req` and `reg_rdata` follow their inputs within the same cycle. The bench drives inputs just after the falling edge and compares every output 1 ns later against a behavioural model that is advanced on each rising edge. Each comparison therefore lands after the registers have settled and before the next active edge. Cases include long busy periods, resets written while disabled, both channels written together, and bus-reset pulses.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int NUM_CH    = 2;
    localparam int OFS_CTRL  = 'h000;
    localparam int OFS_SRST  = 'h004;

    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,
        CH_WAIT  = 2'd1,
        CH_FLUSH = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic pend;
        logic flush;
    } ch_stat_t;

    function automatic logic [DATA_W-1:0] ctrl_word(input logic en);
        return {{(DATA_W-1){1'b0}}, en};
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int NCH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_rst,
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          en,
    output logic [NCH-1:0] srst
);

    logic hit_ctrl, hit_srst, wr_ctrl;

    assign hit_ctrl = sel && (addr == AW'(OFS_CTRL));
    assign hit_srst = sel && (addr == AW'(OFS_SRST));
    assign wr_ctrl  = hit_ctrl && we;

    always_ff @(posedge clk) begin
        if (rst)
            en <= 1'b0;
        else if (wr_ctrl)
            en <= wdata[0];
    end

    assign srst  = (hit_srst && we) ? wdata[NCH-1:0] : '0;
    assign rdata = hit_ctrl ? ctrl_word(en) : '0;

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(en)); // R8
    AST_EN_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (wdata[DW-1:1] != '0)) |=> (en == $past(wdata[0]))); // R2
    AST_BUS_RST_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (bus_rst && !wr_ctrl) |=> $stable(en)); // R8

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     srst,
    input  logic     busy,
    input  logic     req,
    output logic     go,
    output logic     xreq,
    output ch_stat_t stat
);

    ch_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_RUN;
        end else begin
            unique case (state)
                CH_RUN:   if (srst) state <= CH_WAIT;
                CH_WAIT:  if (!busy) state <= CH_FLUSH;
                CH_FLUSH: state <= srst ? CH_WAIT : CH_RUN;
                default:  state <= CH_RUN;
            endcase
        end
    end

    assign stat.pend  = (state != CH_RUN);
    assign stat.flush = (state == CH_FLUSH);
    assign go         = en && (state == CH_RUN);
    assign xreq       = req && go;

    AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (rst)
        srst |=> stat.pend); // R4
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stat.flush |=> !stat.flush); // R5
    AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == CH_WAIT && busy) |=> (state == CH_WAIT)); // R6
    AST_NO_FLUSH_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.flush) |-> !$past(busy)); // R6

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int NCH = NUM_CH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           usb_bus_rst,
    input  logic           reg_sel,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] ch_req,
    input  logic [NCH-1:0] ch_busy,
    output logic [NCH-1:0] ch_go,
    output logic [NCH-1:0] ch_xfer_req,
    output logic [NCH-1:0] ch_flush,
    output logic [NCH-1:0] ch_rst_pend
);

    logic           en;
    logic [NCH-1:0] srst;

    dmac_regs #(.AW(AW), .DW(DW), .NCH(NCH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .bus_rst(usb_bus_rst),
        .sel    (reg_sel),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .en     (en),
        .srst   (srst)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_stat_t st;
        dmac_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .en   (en),
            .srst (srst[i]),
            .busy (ch_busy[i]),
            .req  (ch_req[i]),
            .go   (ch_go[i]),
            .xreq (ch_xfer_req[i]),
            .stat (st)
        );
        assign ch_flush[i]    = st.flush;
        assign ch_rst_pend[i] = st.pend;
    end

    AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (ch_go != '0) |-> en); // R3
    AST_XFER_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
        ((ch_xfer_req & ~ch_go) == '0)); // R3

endmodule

// File: tb/sim_dmac_top.sv
module sim_dmac_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        usb_bus_rst = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ch_req = '0, ch_busy = '0;
    logic [1:0]  ch_go, ch_xfer_req, ch_flush, ch_rst_pend;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    dmac_top u0 (.*);

    // behavioural reference
    bit m_en;
    bit m_wait [2];
    bit m_fl   [2];

    always @(posedge clk) begin
        if (rst) begin
            m_en <= 0;
            foreach (m_wait[k]) begin m_wait[k] <= 0; m_fl[k] <= 0; end
        end else begin
            if (reg_sel && reg_we && reg_addr == 12'h000) m_en <= reg_wdata[0];
            foreach (m_wait[k]) begin
                bit sw;
                sw = reg_sel && reg_we && reg_addr == 12'h004 && reg_wdata[k];
                m_fl[k]   <= m_wait[k] && !ch_busy[k];
                m_wait[k] <= m_wait[k] ? ch_busy[k] : sw;
            end
        end
    end

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick(int n = 1);
        for (int c = 0; c < n; c++) begin
            logic [1:0] e_pend, e_fl, e_go;
            #1;
            if (!rst) begin
                for (int k = 0; k < 2; k++) begin
                    e_pend[k] = m_wait[k] | m_fl[k];
                    e_fl[k]   = m_fl[k];
                    e_go[k]   = m_en & ~e_pend[k];
                end
                cmp("pend",  {30'b0, ch_rst_pend}, {30'b0, e_pend});
                cmp("flush", {30'b0, ch_flush},    {30'b0, e_fl});
                cmp("go",    {30'b0, ch_go},       {30'b0, e_go});
                cmp("xreq",  {30'b0, ch_xfer_req}, {30'b0, e_go & ch_req});
                cmp("rdata", reg_rdata, (reg_sel && reg_addr == 12'h000) ? {31'b0, m_en} : 32'h0);
            end
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_sel = 0; reg_we = 0; reg_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a);
        reg_sel = 1; reg_we = 0; reg_addr = a;
        tick();
        reg_sel = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1 reset state
        cur_req = "R1";
        cmp("rst go",   {30'b0, ch_go}, 32'h0);
        cmp("rst pend", {30'b0, ch_rst_pend}, 32'h0);
        rd(12'h000);
        // R2 enable write, reserved bits ignored
        cur_req = "R2";
        wr(12'h000, 32'hFFFF_FFFE); rd(12'h000);
        wr(12'h000, 32'h0000_0001); rd(12'h000);
        // R3 gating and suspend/resume
        cur_req = "R3";
        ch_req = 2'b11; tick(2);
        wr(12'h000, 32'h0); tick(2);
        wr(12'h000, 32'h1); tick(2);
        // R4 and R5 soft resets, idle channels
        cur_req = "R4";
        wr(12'h004, 32'h1); tick(4);
        wr(12'h004, 32'h2); tick(4);
        wr(12'h004, 32'h3); rd(12'h004);
        cmp("srst read", reg_rdata, 32'h0);
        tick(3);
        cur_req = "R5";
        wr(12'h004, 32'h1); tick(1); wr(12'h004, 32'h1); tick(4);
        // R6 busy defers reset
        cur_req = "R6";
        ch_busy = 2'b01;
        wr(12'h004, 32'h3); tick(5);
        ch_busy = 2'b00; tick(4);
        // R7 reset while disabled
        cur_req = "R7";
        wr(12'h000, 32'h0);
        wr(12'h004, 32'h2); tick(4);
        ch_busy = 2'b10; wr(12'h004, 32'h2); tick(3);
        ch_busy = 2'b00; tick(3);
        // R8 bus reset ignored
        cur_req = "R8";
        wr(12'h000, 32'h1);
        ch_busy = 2'b10; wr(12'h004, 32'h2);
        usb_bus_rst = 1; tick(4); rd(12'h000);
        usb_bus_rst = 0; ch_busy = 2'b00; tick(4);
        // R9 address decode
        cur_req = "R9";
        wr(12'h001, 32'h0); rd(12'h000);
        wr(12'h008, 32'h0); rd(12'h008);
        wr(12'h005, 32'h3); tick(3);
        rd(12'h002);
        ch_req = 2'b00; tick(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule